// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification

This block gathers the three request sources of a UART (line error conditions, received data waiting, and transmit holding register empty) and produces three separate request outputs, one per source, each masked by its own enable. At the same time it forms a legacy identification code that names the most urgent pending source. Bit 0 of this code is active low and shows whether anything is pending at all.

The surrounding register logic feeds the block with single-cycle event pulses and levels. These are error events, a received-word load, reads of the receive buffer, the status word and the identification code, and writes to the holding register. It also supplies the level of the holding-register-empty flag. The block holds the latches that remember each request and applies the clearing rules.

Transmit acknowledgement has a special rule. A read of the identification code acknowledges the transmit-empty request only when that request is the one the code reports. While a line or receive request outranks it, the read leaves it pending.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset all three request outputs are low and the identification code is 0x01.
- R2: An event pulse on any of the four error inputs (overrun, parity, framing, break) sets the line latch at the next clock edge. `line_irq` is that latch ANDed with `line_en`. The enable acts in the same cycle, and the latch is kept while the enable is low.
- R3: A `status_read` pulse clears the line latch at the next edge. If an error event arrives in the same cycle as the read, the latch stays set.
- R4: An `rx_load` pulse sets the data-ready latch at the next edge and an `rx_buf_read` pulse clears it. A load in the same cycle as a read wins. `rx_irq` is data-ready ANDed with `rx_en`.
- R5: `tx_irq` rises in the same cycle that `tx_en` rises while `thr_empty` is high. It also rises in the same cycle that `thr_empty` rises while `tx_en` is high.
- R6: A `thr_write` pulse acknowledges the transmit request. `tx_irq` is low from the next cycle until `thr_empty` rises again or `tx_en` rises again.
- R7: An `id_read` pulse while the code reads 0x02 acknowledges the transmit request in the same way as R6.
- R8: An `id_read` pulse while the code reads 0x04 or 0x06 leaves the transmit request pending.
- R9: The code is 0x06 when `line_irq` is high, else 0x04 when `rx_irq` is high, else 0x02 when `tx_irq` is high, else 0x01. Bit 0 is 0 exactly when some request output is high.
- R10: The three request outputs are independent. Each is high whenever its own condition holds, whatever the other two do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | Enable for the line error request |
| rx_en | input | 1 | Enable for the receive data request |
| tx_en | input | 1 | Enable for the transmit empty request |
| err_overrun | input | 1 | Overrun error event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_framing | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break detected event pulse |
| rx_load | input | 1 | Received word moved into the receive buffer |
| rx_buf_read | input | 1 | Receive buffer read |
| status_read | input | 1 | Line status word read |
| thr_empty | input | 1 | Holding register empty level |
| thr_write | input | 1 | Holding register written |
| id_read | input | 1 | Identification code read |
| line_irq | output | 1 | Line error request |
| rx_irq | output | 1 | Receive data request |
| tx_irq | output | 1 | Transmit empty request |
| id_code | output | 8 | Identification code of the highest pending request |

## Verification
Event pulses (errors, loads, reads, writes) pass through exactly one register, so their effect on the outputs is due one clock edge after the pulse. Enable changes and edges of `thr_empty` reach the outputs combinationally in the same cycle. The bench drives every input on the falling edge. It checks pulse effects on the following falling edge, after one rising edge has passed, and it checks combinational effects 1 ns after the drive, before any rising edge. The ordering cases are checked within the cycle where the decision is taken: a read colliding with an event, and an identification read made under a blocking request.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ID_W = 8;
  localparam int NUM_ERR = 4;

  typedef enum logic [ID_W-1:0] {
    ID_NONE = 8'h01,
    ID_TXE  = 8'h02,
    ID_RXD  = 8'h04,
    ID_LINE = 8'h06
  } id_code_e;

  // Priority encode: line over receive over transmit.
  function automatic logic [ID_W-1:0] id_encode(input logic line_r, input logic rx_r,
                                                input logic tx_r);
    if (line_r)    return ID_LINE;
    else if (rx_r) return ID_RXD;
    else if (tx_r) return ID_TXE;
    else           return ID_NONE;
  endfunction

  // Sticky latch next state: a set event outranks a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/uirq_line_req.sv
module uirq_line_req
  import uirq_pkg::*;
#(
  parameter int N_ERR = NUM_ERR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] err_evt,
  input  logic             status_read,
  input  logic             line_en,
  output logic             line_irq
);
  logic [N_ERR-1:0] err_q;
  logic             pend;
  logic             any_evt;

  assign any_evt = |err_evt;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[g] <= 1'b0;
      else        err_q[g] <= sticky_next(err_q[g], err_evt[g], status_read);
    end
  end

  assign pend     = |err_q;
  assign line_irq = pend & line_en;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> pend);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_read && !any_evt) |=> !pend);
endmodule

// File: rtl/uirq_rx_req.sv
module uirq_rx_req
  import uirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_load,
  input  logic rx_buf_read,
  input  logic rx_en,
  output logic rx_irq
);
  logic dr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dr_q <= 1'b0;
    else        dr_q <= sticky_next(dr_q, rx_load, rx_buf_read);
  end

  assign rx_irq = dr_q & rx_en;

  a_r4_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> dr_q);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_buf_read && !rx_load) |=> !dr_q);
endmodule

// File: rtl/uirq_tx_req.sv
module uirq_tx_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic thr_empty,
  input  logic thr_write,
  input  logic id_ack,
  output logic tx_irq
);
  logic ack_q;
  logic empty_prev;
  logic en_prev;
  logic empty_rise;
  logic en_rise;
  logic rearm;
  logic ack_evt;

  assign empty_rise = thr_empty & ~empty_prev;
  assign en_rise    = tx_en & ~en_prev;
  assign rearm      = empty_rise | en_rise;
  assign ack_evt    = thr_write | id_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      empty_prev <= 1'b0;
      en_prev    <= 1'b0;
    end else begin
      empty_prev <= thr_empty;
      en_prev    <= tx_en;
      if (ack_evt)    ack_q <= 1'b1;
      else if (rearm) ack_q <= 1'b0;
    end
  end

  assign tx_irq = tx_en & thr_empty & (~ack_q | rearm);

  a_r5_enable_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !$past(tx_en) && thr_empty) |-> tx_irq);
  a_r6_write_acks: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> (!tx_irq || (thr_empty && !$past(thr_empty)) || (tx_en && !$past(tx_en))));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_en,
  input  logic            rx_en,
  input  logic            tx_en,
  input  logic            err_overrun,
  input  logic            err_parity,
  input  logic            err_framing,
  input  logic            err_break,
  input  logic            rx_load,
  input  logic            rx_buf_read,
  input  logic            status_read,
  input  logic            thr_empty,
  input  logic            thr_write,
  input  logic            id_read,
  output logic            line_irq,
  output logic            rx_irq,
  output logic            tx_irq,
  output logic [ID_W-1:0] id_code
);
  logic [NUM_ERR-1:0] err_evt;
  logic               tx_reported;
  logic               id_ack;
  logic               any_pend;

  assign err_evt = {err_break, err_framing, err_parity, err_overrun};

  uirq_line_req #(.N_ERR(NUM_ERR)) i_line (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .status_read(status_read),
    .line_en(line_en), .line_irq(line_irq)
  );

  uirq_rx_req i_rx (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rx_buf_read(rx_buf_read),
    .rx_en(rx_en), .rx_irq(rx_irq)
  );

  assign id_code     = id_encode(line_irq, rx_irq, tx_irq);
  assign tx_reported = (id_code == ID_TXE);
  assign id_ack      = id_read & tx_reported;
  assign any_pend    = line_irq | rx_irq | tx_irq;

  uirq_tx_req i_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .thr_empty(thr_empty),
    .thr_write(thr_write), .id_ack(id_ack), .tx_irq(tx_irq)
  );

  a_r9_pending_bit: assert property (@(posedge clk) disable iff (!rst_n)
    id_code[0] == !any_pend);
  a_r8_blocked_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (id_read && tx_irq && (line_irq || rx_irq) && !thr_write)
      |=> (tx_irq || !tx_en || !thr_empty));
  a_r7_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (id_read && tx_irq && !line_irq && !rx_irq && tx_en && thr_empty)
      |=> (!tx_irq || (tx_en && !$past(tx_en)) || (thr_empty && !$past(thr_empty))));
endmodule

// File: tb/test_uart_irq_prio.sv
`timescale 1ns/1ps
module test_uart_irq_prio;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_en = 0, rx_en = 0, tx_en = 0;
  logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
  logic rx_load = 0, rx_buf_read = 0, status_read = 0;
  logic thr_empty = 0, thr_write = 0, id_read = 0;
  logic line_irq, rx_irq, tx_irq;
  logic [7:0] id_code;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_prio i_uart_irq_prio (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .rx_en(rx_en), .tx_en(tx_en),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_framing(err_framing),
    .err_break(err_break), .rx_load(rx_load), .rx_buf_read(rx_buf_read),
    .status_read(status_read), .thr_empty(thr_empty), .thr_write(thr_write),
    .id_read(id_read), .line_irq(line_irq), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .id_code(id_code)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Clear all latches back to idle through the normal interface.
  task automatic quiesce();
    status_read = 1; rx_buf_read = 1; thr_write = 1;
    tick();
    status_read = 0; rx_buf_read = 0; thr_write = 0;
    line_en = 0; rx_en = 0; tx_en = 0; thr_empty = 0;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 line_irq", {7'd0, line_irq}, 8'h00);
    chk("R1 rx_irq", {7'd0, rx_irq}, 8'h00);
    chk("R1 tx_irq", {7'd0, tx_irq}, 8'h00);
    chk("R1 id", id_code, 8'h01);
  endtask

  task automatic t_line_sources();
    for (int k = 0; k < 4; k++) begin
      line_en = 1;
      err_overrun = (k == 0); err_parity = (k == 1);
      err_framing = (k == 2); err_break = (k == 3);
      #1 chk("R2 no effect before edge", {7'd0, line_irq}, 8'h00);
      tick();
      err_overrun = 0; err_parity = 0; err_framing = 0; err_break = 0;
      chk("R2 error sets line", {7'd0, line_irq}, 8'h01);
      chk("R9 line code", id_code, 8'h06);
      line_en = 0;
      #1 chk("R2 enable gates", {7'd0, line_irq}, 8'h00);
      line_en = 1;
      #1 chk("R2 latch kept", {7'd0, line_irq}, 8'h01);
      status_read = 1;
      tick();
      status_read = 0;
      chk("R3 read clears", {7'd0, line_irq}, 8'h00);
    end
    // Collision: event and read in the same cycle.
    err_parity = 1; status_read = 1;
    tick();
    err_parity = 0; status_read = 0;
    chk("R3 event wins over read", {7'd0, line_irq}, 8'h01);
    quiesce();
  endtask

  task automatic t_rx();
    rx_en = 1; rx_load = 1;
    tick();
    rx_load = 0;
    chk("R4 load sets", {7'd0, rx_irq}, 8'h01);
    chk("R9 rx code", id_code, 8'h04);
    rx_en = 0;
    #1 chk("R4 enable gates", {7'd0, rx_irq}, 8'h00);
    rx_en = 1; rx_load = 1; rx_buf_read = 1;
    tick();
    rx_load = 0;
    chk("R4 load wins over read", {7'd0, rx_irq}, 8'h01);
    tick();
    rx_buf_read = 0;
    chk("R4 read clears", {7'd0, rx_irq}, 8'h00);
    chk("R9 none code", id_code, 8'h01);
    quiesce();
  endtask

  task automatic t_tx_raise_and_write();
    thr_empty = 1;
    tick();
    tx_en = 1;
    #1 chk("R5 enable raises now", {7'd0, tx_irq}, 8'h01);
    chk("R9 tx code", id_code, 8'h02);
    tick();
    thr_write = 1;
    tick();
    thr_write = 0;
    chk("R6 write acks", {7'd0, tx_irq}, 8'h00);
    tick();
    chk("R6 stays acked", {7'd0, tx_irq}, 8'h00);
    thr_empty = 0;
    tick();
    thr_empty = 1;
    #1 chk("R5 empty rise raises now", {7'd0, tx_irq}, 8'h01);
    tick();
    chk("R5 stays raised", {7'd0, tx_irq}, 8'h01);
    quiesce();
  endtask

  task automatic t_tx_id_read();
    thr_empty = 1; tx_en = 1;
    tick();
    chk("R7 pre", id_code, 8'h02);
    id_read = 1;
    tick();
    id_read = 0;
    chk("R7 id read acks", {7'd0, tx_irq}, 8'h00);
    chk("R7 id after", id_code, 8'h01);
    // Re-enable re-raises.
    tx_en = 0;
    tick();
    tx_en = 1;
    #1 chk("R6 re-enable raises", {7'd0, tx_irq}, 8'h01);
    tick();
    // Blocked by line.
    line_en = 1; err_break = 1;
    tick();
    err_break = 0;
    chk("R9 line outranks tx", id_code, 8'h06);
    id_read = 1;
    tick();
    id_read = 0;
    chk("R8 blocked by line", {7'd0, tx_irq}, 8'h01);
    status_read = 1;
    tick();
    status_read = 0;
    chk("R8 tx still reported", id_code, 8'h02);
    // Blocked by rx.
    rx_en = 1; rx_load = 1;
    tick();
    rx_load = 0;
    chk("R9 rx outranks tx", id_code, 8'h04);
    id_read = 1;
    tick();
    id_read = 0;
    chk("R8 blocked by rx", {7'd0, tx_irq}, 8'h01);
    quiesce();
  endtask

  task automatic t_independent();
    line_en = 1; rx_en = 1; tx_en = 1; thr_empty = 1;
    err_framing = 1; rx_load = 1;
    tick();
    err_framing = 0; rx_load = 0;
    chk("R10 all three high", {5'd0, line_irq, rx_irq, tx_irq}, 8'h07);
    chk("R9 top priority", id_code, 8'h06);
    rx_en = 0;
    #1 chk("R10 rx off others stay", {5'd0, line_irq, rx_irq, tx_irq}, 8'h05);
    line_en = 0;
    #1 chk("R10 tx alone", {5'd0, line_irq, rx_irq, tx_irq}, 8'h01);
    chk("R9 tx code alone", id_code, 8'h02);
    quiesce();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_line_sources();
    t_rx();
    t_tx_raise_and_write();
    t_tx_id_read();
    t_independent();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule